// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is an I2C target that looks to a bus controller like a small serial EEPROM. It samples the open-drain clock and data lines with the system clock. It pulls the data line low only to acknowledge bytes and to send read data. Each transfer opens with a device byte. The master then sends a two-byte memory address and follows it with data to store. It can also issue a repeated start and read bytes one after another from the address pointer.

Storage is an internal byte array of `2**AW` entries. Writes move the pointer inside one page of `2**PAGE_AW` bytes, while reads move it across the whole array. When `STRETCH_CYC` is nonzero, the target also holds the clock line low for a fixed time after each byte it has taken part in.

Top module: `i2c_ee_slave`

## Requirements
- R1: A start condition (data falls while clock is high) always restarts byte framing and expects a device byte, even in the middle of a byte. A stop condition (data rises while clock is high) releases the data line and ends the transfer.
- R2: The device byte is {7-bit address, direction bit}, MSB first, with direction 1 meaning read. The target acknowledges it only when the address equals `DEV_ADDR`. On a mismatch it leaves data released (NACK) for that byte and for every later byte until the next start.
- R3: During a write, the target acknowledges every byte it receives by pulling data low for the ninth clock of that byte.
- R4: The two bytes after a write device byte form the memory address, high byte first. The pointer keeps only the low `AW` bits of that 16-bit value.
- R5: Each data byte is stored at the pointer. Only the low `PAGE_AW` bits of the pointer then increment, wrapping within the page, so that writing past the page end overwrites the page start and leaves the next page untouched.
- R6: During a read, the target sends the byte at the pointer, MSB first, and the pointer increments over the whole array, wrapping from `2**AW-1` to 0.
- R7: When the master answers a read byte with NACK (data high on the ninth clock), the target releases data and drives nothing until the next start or stop.
- R8: A write transfer stopped right after the two address bytes stores nothing. It still loads the pointer, so that a later read device byte sent directly after a start returns the byte at that address.
- R9: The target changes its data drive only while the clock line is low.
- R10: With `STRETCH_CYC` > 0, after the ninth clock of each byte that leaves the transfer active, the target holds the clock low for exactly `STRETCH_CYC` system clocks starting from the falling edge. With `STRETCH_CYC` = 0, the target never drives the clock.
- R11: Both line outputs are pull-low enables (1 = drive low, 0 = released), and both are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The assertions assume that the master changes data only while the clock is low, except when it creates a start or a stop. They also assume that every line level lasts several system clocks, so that the synchronizer keeps the order of clock and data edges. The bench master holds each half bit for ten system clocks. It moves data only in the low phase, and it waits for the clock line to read high before it counts its high time, so a stretch is honoured. Under those conditions, start and stop are detected only where the master means them. The data drive then never moves while the clock is high.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD
   } ee_state_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_prev, sda_prev;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_ee_stretch.sv
module i2c_ee_stretch #(
   parameter int STRETCH_CYC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic hold
);
   localparam int CW = $clog2(STRETCH_CYC + 1) + 1;
   localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);
   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (trig)           remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign hold = (remain != '0);
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
   import i2c_ee_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         AW          = 10,
   parameter int         PAGE_AW     = 6,
   parameter int         STRETCH_CYC = 0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_oe,
   output logic sda_oe
);
   localparam logic [3:0] ACK_SLOT = 4'd8;

   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("AW must be within 1..16");
      end
      if (PAGE_AW < 1 || PAGE_AW > AW) begin : g_bad_page
         $error("PAGE_AW must be within 1..AW");
      end
      if (STRETCH_CYC < 0) begin : g_bad_str
         $error("STRETCH_CYC must not be negative");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   ee_state_t     state;
   logic [3:0]    cnt;
   logic [7:0]    sr, hi;
   logic [AW-1:0] ptr, wr_next, rd_next;
   logic [7:0]    rdata;
   logic          ack_done, ack_ok, mem_we, active, stretch_trig;

   i2c_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_ee_mem #(.AW(AW)) u_mem (
      .clk(clk), .we(mem_we), .waddr(ptr), .wdata(sr),
      .raddr(ptr), .rdata(rdata)
   );

   i2c_ee_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
      .clk(clk), .rst_n(rst_n), .trig(stretch_trig), .hold(scl_oe)
   );

   generate
      if (PAGE_AW == AW) begin : g_page_all
         assign wr_next = ptr + 1'b1;
      end else begin : g_page_part
         logic [PAGE_AW-1:0] low_inc;
         assign low_inc = ptr[PAGE_AW-1:0] + 1'b1;
         assign wr_next = {ptr[AW-1:PAGE_AW], low_inc};
      end
   endgenerate

   assign rd_next = ptr + 1'b1;
   assign active  = (state != ST_IDLE) && !start_det && !stop_det;
   assign ack_ok  = (state == ST_DEV) ? (sr[7:1] == DEV_ADDR) : 1'b1;
   assign mem_we  = active && scl_rise && (cnt == ACK_SLOT) && (state == ST_WR);
   assign stretch_trig = active && scl_fall && ack_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sr       <= '0;
         hi       <= '0;
         ptr      <= '0;
         sda_oe   <= 1'b0;
         ack_done <= 1'b0;
      end else if (start_det) begin
         state    <= ST_DEV;
         cnt      <= '0;
         sda_oe   <= 1'b0;
         ack_done <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         sda_oe   <= 1'b0;
         ack_done <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (cnt != ACK_SLOT) begin
               sr  <= {sr[6:0], sda_s};
               cnt <= cnt + 1'b1;
            end else begin
               cnt      <= '0;
               ack_done <= 1'b1;
               case (state)
                  ST_DEV:  state <= !ack_ok ? ST_IDLE : (sr[0] ? ST_RD : ST_AHI);
                  ST_AHI: begin
                     hi    <= sr;
                     state <= ST_ALO;
                  end
                  ST_ALO: begin
                     ptr   <= AW'({hi, sr});
                     state <= ST_WR;
                  end
                  ST_WR:   ptr <= wr_next;
                  ST_RD: begin
                     ptr <= rd_next;
                     if (sda_s) state <= ST_IDLE;
                  end
                  default: state <= ST_IDLE;
               endcase
            end
         end else if (scl_fall) begin
            ack_done <= 1'b0;
            if (state == ST_RD)
               sda_oe <= (cnt < ACK_SLOT) ? ~rdata[~cnt[2:0]] : 1'b0;
            else
               sda_oe <= (cnt == ACK_SLOT) ? ack_ok : 1'b0;
         end
      end
   end

   // Assertions
   assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);

   assert_start_reframe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV && cnt == 4'd0 && !sda_oe));

   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   assert_mismatch_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV && cnt == ACK_SLOT && sr[7:1] != DEV_ADDR) |-> !sda_oe);

   assert_stretch_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> !scl_s);

   generate
      if (PAGE_AW < AW) begin : g_page_chk
         assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we |=> (ptr[AW-1:PAGE_AW] == $past(ptr[AW-1:PAGE_AW])));
      end
   endgenerate
endmodule

// File: tb/test_i2c_ee_slave.sv
module test_i2c_ee_slave;
   localparam int AW = 10;
   localparam int MASK = (1 << AW) - 1;
   localparam int STR = 20;
   localparam int Q = 10;
   localparam logic [6:0] DEV = 7'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_oe, sda_oe, scl_line, sda_line;
   int nchk = 0, nerr = 0, mon_err = 0, str_cycles = 0;
   logic [7:0] ref_mem [1 << AW];
   int ref_ptr = 0;
   logic prev_scl = 1'b1, prev_oe = 1'b0;

   always #5 clk = ~clk;
   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   i2c_ee_slave #(.DEV_ADDR(DEV), .AW(AW), .PAGE_AW(6), .STRETCH_CYC(STR)) i_i2c_ee_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   // per-clock monitor: data drive must hold while clock line stays high (R9)
   always @(negedge clk) begin
      if (rst_n && scl_line && prev_scl && sda_oe != prev_oe) mon_err++;
      if (scl_oe) str_cycles++;
      prev_scl = scl_line;
      prev_oe  = sda_oe;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_high();
      @(negedge clk);
      while (!scl_line) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic r);
      m_sda = b; wt(Q);
      m_scl = 1'b1; wait_high(); wt(Q);
      r = sda_line;
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wait_high(); wt(Q);
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b1; wait_high(); wt(Q);
      m_sda = 1'b1; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      ack = !r;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, r);
         b[i] = r;
      end
      clk_bit(!mack, r);
   endtask

   task automatic set_addr(input logic [15:0] a);
      logic ack;
      i2c_start();
      send_byte({DEV, 1'b0}, ack); chk("R2 device ack", ack, 1);
      send_byte(a[15:8], ack);     chk("R4 addr hi ack", ack, 1);
      send_byte(a[7:0], ack);      chk("R4 addr lo ack", ack, 1);
      ref_ptr = a & MASK;
   endtask

   task automatic wr_txn(input logic [15:0] a, input int n, input logic [7:0] base);
      logic ack;
      set_addr(a);
      for (int i = 0; i < n; i++) begin
         send_byte(base + 8'(i), ack);
         chk("R3 data ack", ack, 1);
         ref_mem[ref_ptr] = base + 8'(i);
         ref_ptr = (ref_ptr & ~63) | ((ref_ptr + 1) & 63);
      end
      i2c_stop();
   endtask

   task automatic rd_current(input int n, input string req);
      logic ack;
      logic [7:0] b;
      i2c_start();
      send_byte({DEV, 1'b1}, ack); chk("R2 read device ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         chk(req, b, ref_mem[ref_ptr]);
         ref_ptr = (ref_ptr + 1) & MASK;
      end
   endtask

   task automatic rd_random(input logic [15:0] a, input int n, input string req);
      set_addr(a);
      rd_current(n, req);
      i2c_stop();
   endtask

   initial begin
      logic ack, r;
      int highs;
      wt(5);
      chk("R11 reset sda_oe", sda_oe, 0);
      chk("R11 reset scl_oe", scl_oe, 0);
      rst_n = 1'b1;
      wt(5);

      // basic write then random read, MSB first (R3 R4 R6)
      wr_txn(16'h0010, 3, 8'h11);
      rd_random(16'h0010, 3, "R6 sequential read");

      // address-only write, then current-address read (R8), then NACK release (R7)
      set_addr(16'h0012);
      i2c_stop();
      rd_current(1, "R8 current address read");
      highs = 0;
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, r);
         highs += int'(r);
      end
      chk("R7 released after NACK", highs, 9);
      i2c_stop();

      // address mismatch: NACK on every byte until the next start (R2)
      i2c_start();
      send_byte({7'h51, 1'b0}, ack); chk("R2 mismatch nack", ack, 0);
      send_byte(8'h00, ack);         chk("R2 ignored byte", ack, 0);
      send_byte(8'h10, ack);         chk("R2 ignored byte", ack, 0);
      i2c_stop();
      rd_random(16'h0010, 1, "R2 memory untouched");

      // start in mid byte restarts framing (R1)
      i2c_start();
      for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
      wr_txn(16'h0100, 1, 8'h77);
      rd_random(16'h0100, 1, "R1 restart framing");

      // page wrap on write (R5): next page byte stays
      wr_txn(16'h0040, 1, 8'h5A);
      wr_txn(16'h003E, 66, 8'hA0);
      rd_random(16'h0000, 65, "R5 page wrap");

      // upper address bits dropped (R4) and full-array read wrap (R6)
      wr_txn(16'hFFFE, 2, 8'hC1);
      rd_random(16'h03FE, 4, "R6 array wrap");

      // clock stretch length (R10): five acknowledged bytes
      wt(50);
      str_cycles = 0;
      wr_txn(16'h0200, 2, 8'h30);
      wt(50);
      chk("R10 stretch cycles", str_cycles, 5 * STR);

      chk("R9 drive changes only with clock low", mon_err, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule